// File: doc/BRIEF.md
# Prioritized Maskable Interrupt Controller

This block arbitrates interrupt requests for a CPU core and holds the core's 16-bit status word. Three fixed sources feed it: an external request, a horizontal-blank request and a vertical-blank request. A fourth line carries the top-priority request. Each source owns a fixed priority level. The controller keeps a pending bit per level and compares the highest pending level with the 3-bit priority mask stored in the status word. It then presents an encoded level and a valid flag to the core.

The core writes the status word through a write port. A supervisor qualifier decides whether the control byte may change. The core reads the word back through a read-only port. When the core takes an interrupt, it returns the serviced level on the acknowledge port. The controller then raises the mask to that level and retires the matching pending bit. The condition flags are only stored here; no arithmetic is done on them.

Top module: `irq_ctrl_top`

## Requirements
- R1: After a synchronous active-low reset, `sr_rdata` reads 16'h2700, every pending request is cleared, and `irq_valid` is 0 with `irq_level` 0.
- R2: The status word places trace at bit 15, supervisor at bit 13, the mask at bits 10:8 (bit 10 most significant) and the flags at bits 4:0. Bits 14, 12, 11 and 7:5 always read 0.
- R3: A write with `sr_super` high updates trace, supervisor, mask and flags. Writing 16'h2700 reads back with supervisor set and mask 7, and writing 16'h2300 reads back with supervisor set and mask 3.
- R4: A write with `sr_super` low updates only bits 4:0. Bits 15:8 keep their value.
- R5: The source levels are fixed: `ext_req` is level 2, `hblank_req` is level 4, `vblank_req` is level 6 and `nmi_req` is level 7.
- R6: A pending level at or below the mask value is not presented. Level 7 is presented whatever the mask holds, including mask 7.
- R7: Among the pending levels that pass the mask, the highest is output on `irq_level`. With none, `irq_level` is 0 and `irq_valid` is 0; otherwise `irq_valid` is 1.
- R8: Levels 1 to 6 set their pending bit on any cycle when the input is high. The bit stays set after the input falls until that level is acknowledged.
- R9: Level 7 is captured on a rising edge of `nmi_req`. A line held high is serviced once, and a new rising edge raises it again.
- R10: An acknowledge with a nonzero `ack_level` loads the mask with that level and clears that level's pending bit. The acknowledge takes precedence over a supervisor write in the same cycle for the mask field. A level input still high during the acknowledge keeps its bit set.
- R11: Outputs follow the registered state: a request input sampled at a clock edge is reflected on `irq_level` right after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sr_we | input | 1 | Status word write strobe |
| sr_super | input | 1 | Write issued in supervisor state |
| sr_wdata | input | 16 | Status word write data |
| sr_rdata | output | 16 | Status word read data |
| ext_req | input | 1 | External request (level 2) |
| hblank_req | input | 1 | Horizontal-blank request (level 4) |
| vblank_req | input | 1 | Vertical-blank request (level 6) |
| nmi_req | input | 1 | Non-maskable request (level 7, edge) |
| ack_valid | input | 1 | Core accepts an interrupt |
| ack_level | input | 3 | Level being serviced |
| irq_level | output | 3 | Highest permitted pending level, 0 if none |
| irq_valid | output | 1 | A permitted request is pending |

## Verification
The arbitration is swept over every mask value (0 to 7) against all 16 on/off patterns of the four request lines. This sweep separates an at-or-below comparison from a strictly-below comparison, shows that level 7 passes mask 7, and confirms that the highest level wins over each lower combination. Directed sequences then cover status writes in both privilege states, acknowledges that uncover a lower level after the mask is lowered again, a one-cycle pulse that must stay pending, and a held level-7 line that must be serviced only once.

// File: rtl/irq_pkg.sv
// Package: shared widths, level assignments and status word bit positions
// for the interrupt controller. Assumes levels are numbered 1..NUM_LVL.
package irq_pkg;
    localparam int LVL_W   = 3;
    localparam int NUM_LVL = (1 << LVL_W) - 1;
    localparam int SR_W    = 16;
    localparam int FLG_W   = 5;

    localparam int LVL_EXT = 2;
    localparam int LVL_HBL = 4;
    localparam int LVL_VBL = 6;
    localparam int LVL_NMI = NUM_LVL;

    localparam int POS_TRACE = 15;
    localparam int POS_SUPER = 13;
    localparam int POS_MSK_L = 8;
    localparam int POS_MSK_H = POS_MSK_L + LVL_W - 1;

    localparam logic [SR_W-1:0] SR_RESET = 16'h2700;
endpackage

// File: rtl/irq_sr_reg.sv
// Status word storage. Holds trace, supervisor, mask and flags. Writes in
// user state touch the flags only. An acknowledge overrides the mask field.
// Assumes ack_level is 0 or a valid level.
module irq_sr_reg
    import irq_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic             super_wr,
    input  logic [SR_W-1:0]  wdata,
    input  logic             ack_valid,
    input  logic [LVL_W-1:0] ack_level,
    output logic [SR_W-1:0]  rdata,
    output logic [LVL_W-1:0] mask
);
    logic             trace_q;
    logic             super_q;
    logic [LVL_W-1:0] mask_q;
    logic [FLG_W-1:0] flg_q;
    logic             ack_load;

    assign ack_load = ack_valid && (ack_level != '0);

    // Update the status fields from writes, acknowledges and reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            trace_q <= SR_RESET[POS_TRACE];
            super_q <= SR_RESET[POS_SUPER];
            mask_q  <= SR_RESET[POS_MSK_H:POS_MSK_L];
            flg_q   <= SR_RESET[FLG_W-1:0];
        end else begin
            if (we) begin
                flg_q <= wdata[FLG_W-1:0];
                if (super_wr) begin
                    trace_q <= wdata[POS_TRACE];
                    super_q <= wdata[POS_SUPER];
                    mask_q  <= wdata[POS_MSK_H:POS_MSK_L];
                end
            end
            if (ack_load)
                mask_q <= ack_level;
        end
    end

    // Assemble the read word; unused positions read zero.
    always_comb begin
        rdata                       = '0;
        rdata[POS_TRACE]            = trace_q;
        rdata[POS_SUPER]            = super_q;
        rdata[POS_MSK_H:POS_MSK_L]  = mask_q;
        rdata[FLG_W-1:0]            = flg_q;
    end

    assign mask = mask_q;

    assert_user_keeps_ctrl_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (we && !super_wr && !ack_load) |=> $stable(rdata[SR_W-1:8]));

    assert_ack_loads_mask_R10: assert property (@(posedge clk) disable iff (!rst_n)
        ack_load |=> (mask == $past(ack_level)));
endmodule

// File: rtl/irq_pend.sv
// Pending request bits, one per level. Levels below the top are
// level-sensitive; the top level is edge-captured when NMI_EN is set.
// Assumes clr carries at most one bit per cycle.
module irq_pend
    import irq_pkg::*;
#(
    parameter bit NMI_EN = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NUM_LVL:1] req_in,
    input  logic [NUM_LVL:1] clr,
    output logic [NUM_LVL:1] pend
);
    for (genvar l = 1; l <= NUM_LVL; l++) begin : g_lvl
        if (l == NUM_LVL) begin : g_edge
            if (NMI_EN) begin : g_on
                logic prev_q;
                logic rise;
                assign rise = req_in[l] && !prev_q;
                // Capture a rising edge of the top request and hold until acknowledged.
                always_ff @(posedge clk) begin
                    if (!rst_n) begin
                        prev_q  <= 1'b0;
                        pend[l] <= 1'b0;
                    end else begin
                        prev_q  <= req_in[l];
                        pend[l] <= rise || (pend[l] && !clr[l]);
                    end
                end

                assert_nmi_once_R9: assert property (@(posedge clk) disable iff (!rst_n)
                    (clr[l] && prev_q && req_in[l]) |=> !pend[l]);
            end else begin : g_off
                assign pend[l] = 1'b0;
            end
        end else begin : g_level
            // Set while the input is high, hold until acknowledged.
            always_ff @(posedge clk) begin
                if (!rst_n)
                    pend[l] <= 1'b0;
                else
                    pend[l] <= req_in[l] || (pend[l] && !clr[l]);
            end

            assert_level_sets_R8: assert property (@(posedge clk) disable iff (!rst_n)
                req_in[l] |=> pend[l]);
        end
    end
endmodule

// File: rtl/irq_arb.sv
// Priority arbiter: picks the highest pending level above the mask; the top
// level ignores the mask. Purely combinational.
module irq_arb
    import irq_pkg::*;
(
    input  logic [NUM_LVL:1] pend,
    input  logic [LVL_W-1:0] mask,
    output logic [LVL_W-1:0] level,
    output logic             valid
);
    // Scan upward so the last permitted hit is the highest level.
    always_comb begin
        level = '0;
        for (int l = 1; l <= NUM_LVL; l++) begin
            if (pend[l] && ((LVL_W'(l) > mask) || (l == NUM_LVL)))
                level = LVL_W'(l);
        end
        valid = (level != '0);
    end
endmodule

// File: rtl/irq_ctrl_top.sv
// Interrupt controller top: maps the named sources onto levels, keeps the
// status word and presents the highest permitted pending level.
// Assumes the core acknowledges only levels it has been offered.
module irq_ctrl_top
    import irq_pkg::*;
#(
    parameter bit NMI_EN = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sr_we,
    input  logic             sr_super,
    input  logic [15:0]      sr_wdata,
    output logic [15:0]      sr_rdata,
    input  logic             ext_req,
    input  logic             hblank_req,
    input  logic             vblank_req,
    input  logic             nmi_req,
    input  logic             ack_valid,
    input  logic [2:0]       ack_level,
    output logic [2:0]       irq_level,
    output logic             irq_valid
);
    logic [NUM_LVL:1] req_vec;
    logic [NUM_LVL:1] clr_vec;
    logic [NUM_LVL:1] pend;
    logic [LVL_W-1:0] mask;

    // Route each named source to its fixed level.
    always_comb begin
        req_vec          = '0;
        req_vec[LVL_EXT] = ext_req;
        req_vec[LVL_HBL] = hblank_req;
        req_vec[LVL_VBL] = vblank_req;
        req_vec[LVL_NMI] = nmi_req;
    end

    // Decode the acknowledged level into a one-hot clear.
    always_comb begin
        for (int l = 1; l <= NUM_LVL; l++)
            clr_vec[l] = ack_valid && (ack_level == LVL_W'(l));
    end

    irq_sr_reg u_sr (
        .clk       (clk),
        .rst_n     (rst_n),
        .we        (sr_we),
        .super_wr  (sr_super),
        .wdata     (sr_wdata),
        .ack_valid (ack_valid),
        .ack_level (ack_level),
        .rdata     (sr_rdata),
        .mask      (mask)
    );

    irq_pend #(.NMI_EN(NMI_EN)) u_pend (
        .clk    (clk),
        .rst_n  (rst_n),
        .req_in (req_vec),
        .clr    (clr_vec),
        .pend   (pend)
    );

    irq_arb u_arb (
        .pend  (pend),
        .mask  (mask),
        .level (irq_level),
        .valid (irq_valid)
    );

    assert_mask_blocks_R6: assert property (@(posedge clk) disable iff (!rst_n)
        irq_valid |-> ((irq_level > sr_rdata[10:8]) || (irq_level == 3'd7)));

    assert_clr_onehot_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(clr_vec));
endmodule

// File: tb/irq_ctrl_top_tb.sv
`timescale 1ns/1ps
module irq_ctrl_top_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sr_we = 1'b0;
    logic        sr_super = 1'b0;
    logic [15:0] sr_wdata = '0;
    logic [15:0] sr_rdata;
    logic        ext_req = 1'b0;
    logic        hblank_req = 1'b0;
    logic        vblank_req = 1'b0;
    logic        nmi_req = 1'b0;
    logic        ack_valid = 1'b0;
    logic [2:0]  ack_level = '0;
    logic [2:0]  irq_level;
    logic        irq_valid;

    int n_chk = 0;
    int n_bad = 0;

    always #10 clk = ~clk;

    irq_ctrl_top dut_i (
        .clk(clk), .rst_n(rst_n), .sr_we(sr_we), .sr_super(sr_super),
        .sr_wdata(sr_wdata), .sr_rdata(sr_rdata), .ext_req(ext_req),
        .hblank_req(hblank_req), .vblank_req(vblank_req), .nmi_req(nmi_req),
        .ack_valid(ack_valid), .ack_level(ack_level),
        .irq_level(irq_level), .irq_valid(irq_valid)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        step();
        rst_n = 1'b1;
    endtask

    task automatic wr_sr(input logic [15:0] v, input logic sup);
        sr_we = 1'b1; sr_super = sup; sr_wdata = v;
        step();
        sr_we = 1'b0; sr_super = 1'b0;
    endtask

    task automatic ack(input logic [2:0] lv);
        ack_valid = 1'b1; ack_level = lv;
        step();
        ack_valid = 1'b0; ack_level = '0;
    endtask

    initial begin
        #(200000 * 20);
        n_bad++;
        $display("FAIL watchdog actual=running expected=done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        step();
        do_reset();
        // R1: reset state
        chk("R1 sr", sr_rdata, 16'h2700);
        chk("R1 valid", irq_valid, 0);
        chk("R1 level", irq_level, 0);

        // R4: user write changes flags only
        wr_sr(16'hFFFF, 1'b0);
        chk("R4 user write", sr_rdata, 16'h271F);
        // R2/R3: supervisor write, reserved bits read zero
        wr_sr(16'hFFFF, 1'b1);
        chk("R2 layout", sr_rdata, 16'hA71F);
        wr_sr(16'h2700, 1'b1);
        chk("R3 2700", sr_rdata, 16'h2700);
        wr_sr(16'h2300, 1'b1);
        chk("R3 2300", sr_rdata, 16'h2300);

        // R5 R6 R7 R11: sweep every mask against all request patterns
        for (int m = 0; m < 8; m++) begin
            for (int c = 0; c < 16; c++) begin
                int exp;
                do_reset();
                wr_sr(16'h2000 | (m << 8), 1'b1);
                ext_req = c[0]; hblank_req = c[1]; vblank_req = c[2]; nmi_req = c[3];
                step();
                exp = 0;
                if (c[0] && 2 > m) exp = 2;
                if (c[1] && 4 > m) exp = 4;
                if (c[2] && 6 > m) exp = 6;
                if (c[3]) exp = 7;
                chk($sformatf("R6 R7 m=%0d c=%0d level", m, c), irq_level, exp);
                chk($sformatf("R7 m=%0d c=%0d valid", m, c), irq_valid, exp != 0);
                ext_req = 0; hblank_req = 0; vblank_req = 0; nmi_req = 0;
            end
        end

        // R8: one-cycle pulse stays pending until acknowledged
        do_reset();
        wr_sr(16'h2000, 1'b1);
        ext_req = 1; step(); ext_req = 0;
        step(); step();
        chk("R8 held pending", irq_level, 2);
        ack(3'd2);
        chk("R10 ack mask", sr_rdata, 16'h2200);
        chk("R8 cleared", irq_valid, 0);

        // R10: ack reveals lower level once mask lowered
        do_reset();
        wr_sr(16'h2000, 1'b1);
        vblank_req = 1; hblank_req = 1; step();
        vblank_req = 0; hblank_req = 0;
        chk("R7 vblank first", irq_level, 6);
        ack(3'd6);
        chk("R10 mask 6", sr_rdata, 16'h2600);
        chk("R6 hblank hidden", irq_valid, 0);
        wr_sr(16'h2000, 1'b1);
        chk("R10 hblank next", irq_level, 4);

        // R10: ack wins over supervisor write for the mask
        sr_we = 1; sr_super = 1; sr_wdata = 16'h2100;
        ack_valid = 1; ack_level = 3'd4;
        step();
        sr_we = 0; sr_super = 0; ack_valid = 0; ack_level = 0;
        chk("R10 ack over write", sr_rdata, 16'h2400);

        // R10: level input still high during ack keeps the bit
        do_reset();
        wr_sr(16'h2000, 1'b1);
        hblank_req = 1; step();
        ack(3'd4);
        wr_sr(16'h2000, 1'b1);
        chk("R10 held input re-pends", irq_level, 4);
        hblank_req = 0;

        // R9: held level-7 line serviced once, fresh edge again
        do_reset();
        nmi_req = 1; step();
        chk("R9 nmi mask7", irq_level, 7);
        ack(3'd7);
        step(); step();
        chk("R9 held once", irq_valid, 0);
        nmi_req = 0; step();
        nmi_req = 1; step();
        chk("R9 new edge", irq_level, 7);
        nmi_req = 0;

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule